// File: doc/BRIEF.md
# System Clock Divider and Clock Output Control

This block sets the pace of the bus master and drives the chip's clock output pin. It is controlled through an 8-bit control register. The register selects either full speed or a medium-speed clock enable. The medium-speed enable is the master clock divided by 2, 4, 8, 16 or 32. It comes from a free-running counter as a single-cycle pulse, so the block never gates a clock.

A requested clock multiplication factor arrives on its own write strobe. A switching-mode bit in the register decides when that request takes effect. In the deferred setting, the request is held as pending. The pending value becomes the effective factor on the clock edge where the operating mode enters software standby, watch or subactive. In the immediate setting, the effective factor takes the written value at once.

The clock output pin is a combinational table over three inputs: the operating mode, an external direction bit and the register's stop bit. The table gives the pin's output enable and its value, which is either the running clock or a constant high. The interface has no streaming data, so every pin is a plain level or strobe.

Top module: `sysclk_ctl`

## Requirements
- R1: All register fields reset to 0. A register read returns bit 7 (stop), bit 3 (switching mode) and bits 2:0 (speed code) as last written. Bits 6:4 always read 0. `rd_data` is 0 while `rd_en` is low.
- R2: Speed code 000 gives full speed: `bus_ce` is high on every cycle. The reserved codes 110 and 111 behave the same way.
- R3: Speed codes 001, 010, 011, 100 and 101 give a one-cycle `bus_ce` pulse every 2, 4, 8, 16 and 32 master cycles.
- R4: A new speed code takes effect only at the divider's next terminal count. The interval that is already running completes at the old rate.
- R5: With the switching-mode bit at 0, a factor written on `mult_wr` is held pending and `mult_eff` is unchanged.
- R6: With the switching-mode bit at 0, the pending factor is copied to `mult_eff` on the edge where `mode` changes from another mode into software standby (100), watch (101) or subactive (010).
- R7: With the switching-mode bit at 1, a factor written on `mult_wr` appears on `mult_eff` after that clock edge.
- R8: In hardware standby (mode 111), `clk_pin_oe` is 0 regardless of the direction and stop bits.
- R9: With `dir_out` at 0, `clk_pin_oe` is 0 in every mode.
- R10: With `dir_out` at 1 and stop at 0, `clk_pin_oe` is 1. In active (000), sleep (001), subactive (010) and subsleep (011), the pin follows the master clock. In software standby (100), watch (101) and direct transition (110), the pin is held high.
- R11: With `dir_out` at 1 and stop at 1, `clk_pin_oe` is 1 and the pin is held high in every mode except hardware standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Register read data |
| dir_out | input | 1 | Direction bit for the clock pin |
| mode | input | 3 | Operating mode code |
| mult_wr | input | 1 | Multiplication factor write strobe |
| mult_req | input | 2 | Requested multiplication factor |
| bus_ce | output | 1 | Bus master clock enable |
| clk_pin | output | 1 | Clock pin value |
| clk_pin_oe | output | 1 | Clock pin output enable |
| mult_eff | output | 2 | Effective multiplication factor |

## Verification
The assertions check several rules on every cycle. The reserved register bits must read as zero. The pin must be disabled in hardware standby or with the direction bit low, and must be held high while stop is set. The divider count must stay inside its window, and a divided enable must last a single cycle. In deferred mode the effective factor must stay put except at a standby entry, and in immediate mode a write must land on the next edge. Other behaviour shows only in the bench's scenarios: the exact pulse period for each speed code, the old rate finishing its interval after a speed change, and the pin following the clock on both phases.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [2:0] {
    MD_ACTIVE   = 3'd0,
    MD_SLEEP    = 3'd1,
    MD_SUBACT   = 3'd2,
    MD_SUBSLEEP = 3'd3,
    MD_SWSTBY   = 3'd4,
    MD_WATCH    = 3'd5,
    MD_DIRECT   = 3'd6,
    MD_HWSTBY   = 3'd7
  } mode_e;

  typedef struct packed {
    logic       stop;
    logic       imm;
    logic [2:0] speed;
  } ctl_t;

  // Divide ratio as a power of two; reserved codes map to full speed.
  function automatic logic [2:0] speed_to_log(input logic [2:0] code);
    if (code >= 3'd1 && code <= 3'd5) return code;
    return 3'd0;
  endfunction

  // Modes whose entry applies a pending multiplication factor.
  function automatic logic is_load_mode(input logic [2:0] m);
    return (m == MD_SWSTBY) || (m == MD_WATCH) || (m == MD_SUBACT);
  endfunction

  // Modes in which a running clock pin is parked high.
  function automatic logic is_park_mode(input logic [2:0] m);
    return (m == MD_SWSTBY) || (m == MD_WATCH) || (m == MD_DIRECT);
  endfunction

endpackage

// File: rtl/sysclk_reg.sv
module sysclk_reg
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output ctl_t       ctl,
  output logic [7:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.stop  <= wr_data[7];
      ctl.imm   <= wr_data[3];
      ctl.speed <= wr_data[2:0];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) rd_data = {ctl.stop, 3'b000, ctl.imm, ctl.speed};
  end

  always_comb begin
    assert_reserved_zero_R1: assert (rd_data[6:4] == 3'b000)
      else $error("reserved bits read non-zero");
  end

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_log,
  output logic       bus_ce
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [2:0]       cur_log;
  logic             term;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(cur_log)) mask[i] = 1'b1;
    end
  end

  assign term   = (cnt == mask);
  assign bus_ce = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_log <= '0;
    end else if (term) begin
      cnt     <= '0;
      cur_log <= req_log;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && req_log != 3'd0) |=> !bus_ce);

  assert_count_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= mask);

endmodule

// File: rtl/sysclk_mult.sv
module sysclk_mult
  import sysclk_pkg::*;
#(
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imm,
  input  logic          mult_wr,
  input  logic [MW-1:0] mult_req,
  input  logic [2:0]    mode,
  output logic [MW-1:0] mult_eff
);

  logic [MW-1:0] pend;
  logic [2:0]    mode_q;
  logic          enter;

  assign enter = is_load_mode(mode) && !is_load_mode(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      mult_eff <= '0;
      mode_q   <= MD_ACTIVE;
    end else begin
      mode_q <= mode;
      if (mult_wr) pend <= mult_req;
      if (imm && mult_wr)  mult_eff <= mult_req;
      else if (enter)      mult_eff <= pend;
    end
  end

  assert_deferred_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm && !enter) |=> $stable(mult_eff));

  assert_immediate_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (imm && mult_wr) |=> (mult_eff == $past(mult_req)));

endmodule

// File: rtl/sysclk_pin.sv
module sysclk_pin
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic [2:0] mode,
  input  logic       dir_out,
  input  logic       stop,
  output logic       pin,
  output logic       pin_oe
);

  logic run_clk;

  always_comb begin
    pin_oe  = dir_out && (mode != MD_HWSTBY);
    run_clk = pin_oe && !stop && !is_park_mode(mode);
  end

  assign pin = run_clk ? clk : 1'b1;

  always_comb begin
    assert_hw_standby_R8: assert (!(mode == MD_HWSTBY && pin_oe))
      else $error("pin enabled in hardware standby");
    assert_dir_off_R9: assert (dir_out || !pin_oe)
      else $error("pin enabled with direction low");
    assert_stop_high_R11: assert (!(stop && pin_oe) || pin)
      else $error("stopped pin not high");
  end

endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
  import sysclk_pkg::*;
#(
  parameter int MW    = 2,
  parameter int CNT_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          dir_out,
  input  logic [2:0]    mode,
  input  logic          mult_wr,
  input  logic [MW-1:0] mult_req,
  output logic          bus_ce,
  output logic          clk_pin,
  output logic          clk_pin_oe,
  output logic [MW-1:0] mult_eff
);

  ctl_t       ctl;
  logic [2:0] req_log;

  assign req_log = speed_to_log(ctl.speed);

  sysclk_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .ctl(ctl), .rd_data(rd_data)
  );

  sysclk_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .req_log(req_log), .bus_ce(bus_ce)
  );

  sysclk_mult #(.MW(MW)) u_mult (
    .clk(clk), .rst_n(rst_n), .imm(ctl.imm), .mult_wr(mult_wr),
    .mult_req(mult_req), .mode(mode), .mult_eff(mult_eff)
  );

  sysclk_pin u_pin (
    .clk(clk), .mode(mode), .dir_out(dir_out), .stop(ctl.stop),
    .pin(clk_pin), .pin_oe(clk_pin_oe)
  );

endmodule

// File: tb/sysclk_ctl_test.sv
module sysclk_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       dir_out = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       mult_wr = 1'b0;
  logic [1:0] mult_req = 2'd0;
  logic       bus_ce, clk_pin, clk_pin_oe;
  logic [1:0] mult_eff;

  int applied = 0;
  int miscomp = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  sysclk_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dir_out(dir_out), .mode(mode),
    .mult_wr(mult_wr), .mult_req(mult_req), .bus_ce(bus_ce),
    .clk_pin(clk_pin), .clk_pin_oe(clk_pin_oe), .mult_eff(mult_eff)
  );

  // Driver side: push expected value.
  task automatic expect_v(input int v);
    exp_q.push_back(v);
  endtask

  // Monitor side: pop expected and compare with observed.
  task automatic score(input string req, input int act);
    int e;
    e = exp_q.pop_front();
    applied++;
    if (act != e) begin
      miscomp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, e);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ce();
    do @(negedge clk); while (!bus_ce);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ce);
  endtask

  task automatic mult_write(input logic [1:0] v);
    mult_wr = 1'b1; mult_req = v;
    @(negedge clk);
    mult_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

  initial begin
    int n;
    int hi;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_en = 1'b1;
    expect_v(0); score("R1 reset read", rd_data);
    expect_v(0); score("R1 reset mult_eff", mult_eff);
    expect_v(0); score("R1 reset pin_oe", clk_pin_oe);

    // R1 reserved bits and readback
    reg_write(8'hFF);
    expect_v(8'h8F); score("R1 readback", rd_data);
    rd_en = 1'b0; #1;
    expect_v(0); score("R1 read strobe low", rd_data);
    rd_en = 1'b1;
    reg_write(8'h00);

    // R2 full speed and reserved codes
    for (int c = 0; c < 3; c++) begin
      reg_write(c == 0 ? 8'h00 : (c == 1 ? 8'h06 : 8'h07));
      @(negedge clk); @(negedge clk);
      hi = 0;
      for (int k = 0; k < 10; k++) begin
        if (bus_ce) hi++;
        @(negedge clk);
      end
      expect_v(10); score("R2 full speed ce count", hi);
    end

    // R3 divided periods
    for (int s = 1; s <= 5; s++) begin
      reg_write(8'(s));
      wait_ce(); wait_ce();
      gap(n);
      expect_v(1 << s); score("R3 divide period", n);
    end

    // R4 change at terminal count: currently /32
    wait_ce();
    wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    n = 1;
    while (!bus_ce) begin @(negedge clk); n++; end
    expect_v(32); score("R4 old rate completes", n);
    gap(n);
    expect_v(2); score("R4 new rate", n);

    // R5 / R6 deferred factor
    reg_write(8'h00);
    mult_write(2'd3);
    expect_v(0); score("R5 deferred hold", mult_eff);
    mode = 3'd1; @(negedge clk);
    expect_v(0); score("R5 sleep no load", mult_eff);
    mode = 3'd4; @(negedge clk);
    expect_v(3); score("R6 software standby load", mult_eff);
    mult_write(2'd1);
    expect_v(3); score("R5 hold inside standby", mult_eff);
    mode = 3'd5; @(negedge clk);
    expect_v(3); score("R6 no reload between load modes", mult_eff);
    mode = 3'd0; @(negedge clk);
    mode = 3'd2; @(negedge clk);
    expect_v(1); score("R6 subactive load", mult_eff);
    mode = 3'd0; @(negedge clk);

    // R7 immediate factor
    reg_write(8'h08);
    mult_write(2'd2);
    expect_v(2); score("R7 immediate apply", mult_eff);

    // R8..R11 pin table
    for (int st = 0; st < 2; st++) begin
      reg_write(st == 1 ? 8'h80 : 8'h00);
      for (int d = 0; d < 2; d++) begin
        dir_out = d[0];
        for (int m = 0; m < 8; m++) begin
          int e_oe;
          int e_lo;
          mode = 3'(m);
          e_oe = (d == 1 && m != 7) ? 1 : 0;
          e_lo = (e_oe == 1 && st == 0 && m <= 3) ? 0 : 1;
          #1;
          expect_v(e_oe);
          if (m == 7) score("R8 hw standby oe", clk_pin_oe);
          else if (d == 0) score("R9 dir low oe", clk_pin_oe);
          else if (st == 0) score("R10 oe", clk_pin_oe);
          else score("R11 oe", clk_pin_oe);
          if (e_oe == 1) begin
            expect_v(e_lo);
            if (st == 0) score("R10 pin low phase", clk_pin);
            else score("R11 pin held high", clk_pin);
            @(posedge clk); #1;
            expect_v(1);
            if (st == 0) score("R10 pin high phase", clk_pin);
            else score("R11 pin high phase", clk_pin);
          end
          @(negedge clk);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

endmodule